// File: doc/BRIEF.md
# Streaming 3x3 Convolution Datapath

This block is the arithmetic core of a 3x3 image filter. On every clock it receives a full 3x3 window of 8-bit pixel taps and nine 8-bit filter weights. It multiplies each tap by its weight and sums the nine products. It can also add a 16-bit cascade term, shifted left by a selectable amount. The result is registered onto a 20-bit output, optionally rounded to its upper 16 or upper 8 bits. Forming the window from a raster stream and storing the weights are the job of neighbouring blocks.

Mode inputs pick unsigned or two's-complement interpretation, separately for the pixels and for the weights. They also choose the cascade shift and the rounding mode, and whether the cascade adder takes part. The cascade input lets several such cores be chained for larger kernels, or lets a constant offset be added to the result. A registered hold input stalls the whole pipeline. A frame-clear input flushes it between images and leaves the mode inputs in charge.

Top module: `conv3x3_core`

## Requirements
- R1: With cascade off and no rounding, the output is the low 20 bits of the sum over k = 0..8 of tap k times weight k. Tap k sits at pix_taps[8k+7:8k] and weight k at coef_taps[8k+7:8k]. Tap 0 is the top-left of the oldest row, and tap 8 is the bottom-right of the newest row.
- R2: pix_signed = 1 reads every tap as two's complement, and pix_signed = 0 reads it as unsigned. The weights' format does not depend on this input.
- R3: coef_signed = 1 reads every weight as two's complement, and coef_signed = 0 reads it as unsigned. The pixels' format does not depend on this input.
- R4: With casc_bypass = 0, casc_in is zero-extended and shifted left by 0, 2, 4 or 8 bits for casc_shift codes 00, 01, 10 and 11. It is then added to the sum of products, and the total wraps modulo 2^20.
- R5: With casc_bypass = 1, the value on casc_in has no effect on the output.
- R6: round_mode = 01 adds 8 to the 20-bit total, then forces output bits 3..0 to zero. The total wraps modulo 2^20.
- R7: round_mode = 10 adds 0x800, then forces bits 11..0 to zero. Codes 00 and 11 pass the total through unchanged.
- R8: The result for the inputs sampled at clock edge n appears on the output after edge n+2.
- R9: If hold is high at edge n, edge n+1 updates no register, and the output keeps its value.
- R10: If rst_n is low at an edge, the output is zero after that edge. The hold state is cleared as well.
- R11: If frame_clr is high at an edge, the output is zero after that edge and after the next one. This takes precedence over hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | Stall request, takes effect one edge later |
| frame_clr | input | 1 | Synchronous flush of the pipeline registers |
| pix_taps | input | 72 | Nine 8-bit window taps, tap k at bits 8k+7..8k |
| coef_taps | input | 72 | Nine 8-bit weights, weight k at bits 8k+7..8k |
| pix_signed | input | 1 | 1: taps are two's complement |
| coef_signed | input | 1 | 1: weights are two's complement |
| casc_bypass | input | 1 | 1: cascade term forced to zero |
| casc_in | input | 16 | Cascade or offset input, unsigned |
| casc_shift | input | 2 | Cascade left shift code: 0, 2, 4, 8 bits |
| round_mode | input | 2 | 00 none, 01 to 16 bits, 10 to 8 bits, 11 none |
| result | output | 20 | Registered filter output |

## Verification
The output for a set of inputs is due two edges after those inputs are sampled: one edge for the product registers and one for the sum-and-round register. A hold seen at an edge delays everything by exactly one extra edge. The bench keeps a behavioural two-deep model, advances it on each rising edge from the inputs it drove, and compares it with the output at the falling edge. This way, every cycle checks both the value and its timing. The flush and reset cases are checked the same way. Their zeros are expected on the edge that samples the control and on the one after it.

// File: rtl/conv3x3_pkg.sv
// Shared types and helpers for the 3x3 convolution datapath.
// Assumes a 2-bit rounding code and a 2-bit cascade shift code.
package conv3x3_pkg;

    typedef enum logic [1:0] {
        RND_NONE  = 2'b00,
        RND_TOP16 = 2'b01,
        RND_TOP8  = 2'b10,
        RND_RSVD  = 2'b11
    } rnd_mode_e;

    // Map the cascade shift code to a left shift amount in bits.
    function automatic int casc_shamt(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/conv_mac_stage.sv
// First pipeline stage: forms the tap-by-weight products and the shifted
// cascade term, and registers them together with the rounding mode.
// Assumes en is already delayed by the hold logic; clr overrides en.
module conv_mac_stage
    import conv3x3_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int TAPS   = 9,
    parameter int CASC_W = 16,
    parameter int OUT_W  = 20,
    localparam int PROD_W = 2 * (PIX_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic [TAPS*PIX_W-1:0]   pix,
    input  logic [TAPS*PIX_W-1:0]   coef,
    input  logic                    pix_signed,
    input  logic                    coef_signed,
    input  logic [CASC_W-1:0]       casc_in,
    input  logic [1:0]              casc_shift,
    input  logic                    casc_bypass,
    input  logic [1:0]              round_mode,
    output logic [TAPS*PROD_W-1:0]  prod_q,
    output logic [OUT_W-1:0]        casc_q,
    output rnd_mode_e               rmode_q
);

    logic [TAPS*PROD_W-1:0] prod_d;
    logic [OUT_W-1:0]       casc_d;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic signed [PIX_W:0] px;
        logic signed [PIX_W:0] cf;
        assign px = {pix_signed  & pix[k*PIX_W+PIX_W-1],  pix[k*PIX_W +: PIX_W]};
        assign cf = {coef_signed & coef[k*PIX_W+PIX_W-1], coef[k*PIX_W +: PIX_W]};
        assign prod_d[k*PROD_W +: PROD_W] = px * cf;
    end

    // Zero-extend, shift and gate the cascade operand.
    always_comb begin
        if (casc_bypass)
            casc_d = '0;
        else
            casc_d = OUT_W'(casc_in) << casc_shamt(casc_shift);
    end

    // Stage register: cleared by reset or flush, frozen while en is low.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prod_q  <= '0;
            casc_q  <= '0;
            rmode_q <= RND_NONE;
        end else if (en) begin
            prod_q  <= prod_d;
            casc_q  <= casc_d;
            rmode_q <= rnd_mode_e'(round_mode);
        end
    end

    // R5: a bypassed cascade leaves nothing in the stage register.
    a_r5_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_bypass && en) |=> (casc_q == '0));

endmodule

// File: rtl/conv_sum_round.sv
// Second pipeline stage: sums the signed products and the cascade term,
// applies the selected rounding and registers the result.
// Assumes OUT_W is wider than the product width.
module conv_sum_round
    import conv3x3_pkg::*;
#(
    parameter int TAPS   = 9,
    parameter int PROD_W = 18,
    parameter int OUT_W  = 20,
    parameter int KEEP_A = 16,
    parameter int KEEP_B = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic [TAPS*PROD_W-1:0]  prod_q,
    input  logic [OUT_W-1:0]        casc_q,
    input  rnd_mode_e               rmode_q,
    output logic [OUT_W-1:0]        result
);

    localparam int EXT    = OUT_W - PROD_W;
    localparam int DROP_A = OUT_W - KEEP_A;
    localparam int DROP_B = OUT_W - KEEP_B;
    localparam logic [OUT_W-1:0] ONE    = OUT_W'(1);
    localparam logic [OUT_W-1:0] HALF_A = ONE << (DROP_A - 1);
    localparam logic [OUT_W-1:0] HALF_B = ONE << (DROP_B - 1);
    localparam logic [OUT_W-1:0] MASK_A = ~((ONE << DROP_A) - ONE);
    localparam logic [OUT_W-1:0] MASK_B = ~((ONE << DROP_B) - ONE);

    logic [OUT_W-1:0] acc;
    logic [OUT_W-1:0] rnd;

    // Sign-extend each product and accumulate onto the cascade term.
    always_comb begin
        logic [PROD_W-1:0] p;
        acc = casc_q;
        for (int k = 0; k < TAPS; k++) begin
            p   = prod_q[k*PROD_W +: PROD_W];
            acc = acc + {{EXT{p[PROD_W-1]}}, p};
        end
    end

    // Round half-up to the kept width and clear the dropped bits.
    always_comb begin
        case (rmode_q)
            RND_TOP16: rnd = (acc + HALF_A) & MASK_A;
            RND_TOP8:  rnd = (acc + HALF_B) & MASK_B;
            default:   rnd = acc;
        endcase
    end

    // Output register: cleared by reset or flush, frozen while en is low.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            result <= '0;
        else if (en)
            result <= rnd;
    end

    // R6: rounding to the top 16 bits leaves the low nibble clear.
    a_r6_top16_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rmode_q == RND_TOP16 && en && !clr) |=> (result[DROP_A-1:0] == '0));

    // R7: rounding to the top 8 bits leaves the low 12 bits clear.
    a_r7_top8_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rmode_q == RND_TOP8 && en && !clr) |=> (result[DROP_B-1:0] == '0));

endmodule

// File: rtl/conv3x3_core.sv
// Top of the 3x3 convolution datapath: two-stage multiply and sum pipeline
// with a registered stall, a synchronous flush and cascade addition.
// Assumes the window and the weights are presented in parallel each cycle.
module conv3x3_core
    import conv3x3_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int TAPS   = 9,
    parameter int CASC_W = 16,
    parameter int OUT_W  = 20,
    parameter int KEEP_A = 16,
    parameter int KEEP_B = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hold,
    input  logic                   frame_clr,
    input  logic [TAPS*PIX_W-1:0]  pix_taps,
    input  logic [TAPS*PIX_W-1:0]  coef_taps,
    input  logic                   pix_signed,
    input  logic                   coef_signed,
    input  logic                   casc_bypass,
    input  logic [CASC_W-1:0]      casc_in,
    input  logic [1:0]             casc_shift,
    input  logic [1:0]             round_mode,
    output logic [OUT_W-1:0]       result
);

    localparam int PROD_W = 2 * (PIX_W + 1);

    logic                   hold_q;
    logic                   en;
    logic [TAPS*PROD_W-1:0] prod_q;
    logic [OUT_W-1:0]       casc_q;
    rnd_mode_e              rmode_q;

    // Delay the stall request by one edge so it gates the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else
            hold_q <= hold;
    end

    assign en = !hold_q;

    conv_mac_stage #(
        .PIX_W (PIX_W),
        .TAPS  (TAPS),
        .CASC_W(CASC_W),
        .OUT_W (OUT_W)
    ) u_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (frame_clr),
        .en         (en),
        .pix        (pix_taps),
        .coef       (coef_taps),
        .pix_signed (pix_signed),
        .coef_signed(coef_signed),
        .casc_in    (casc_in),
        .casc_shift (casc_shift),
        .casc_bypass(casc_bypass),
        .round_mode (round_mode),
        .prod_q     (prod_q),
        .casc_q     (casc_q),
        .rmode_q    (rmode_q)
    );

    conv_sum_round #(
        .TAPS  (TAPS),
        .PROD_W(PROD_W),
        .OUT_W (OUT_W),
        .KEEP_A(KEEP_A),
        .KEEP_B(KEEP_B)
    ) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (frame_clr),
        .en     (en),
        .prod_q (prod_q),
        .casc_q (casc_q),
        .rmode_q(rmode_q),
        .result (result)
    );

    // R10: an edge that samples reset leaves the output at zero.
    a_r10_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (result == '0));

    // R11: a flush zeroes the output on this edge and on the next.
    a_r11_flush_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clr |-> ##1 (result == '0) ##1 (result == '0));

    // R9: a stall sampled at one edge keeps the output through the next.
    a_r9_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hold ##1 !frame_clr |=> $stable(result));

endmodule

// File: tb/tb_conv3x3_core.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural two-deep model is advanced on each
// rising edge from the driven inputs and compared at every falling edge.
module tb_conv3x3_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0;
    logic        frame_clr = 1'b0;
    logic [71:0] pix_taps = '0;
    logic [71:0] coef_taps = '0;
    logic        pix_signed = 1'b0;
    logic        coef_signed = 1'b0;
    logic        casc_bypass = 1'b1;
    logic [15:0] casc_in = '0;
    logic [1:0]  casc_shift = '0;
    logic [1:0]  round_mode = '0;
    logic [19:0] result;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R10";

    logic [19:0] m_s1 = '0;
    logic [19:0] m_out = '0;
    bit          m_hq = 1'b0;

    always #2 clk = ~clk;

    conv3x3_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .frame_clr  (frame_clr),
        .pix_taps   (pix_taps),
        .coef_taps  (coef_taps),
        .pix_signed (pix_signed),
        .coef_signed(coef_signed),
        .casc_bypass(casc_bypass),
        .casc_in    (casc_in),
        .casc_shift (casc_shift),
        .round_mode (round_mode),
        .result     (result)
    );

    // Expected output for one set of inputs, from the requirements.
    function automatic logic [19:0] expect_of();
        int          acc = 0;
        int          pv;
        int          cv;
        int          sh;
        logic [19:0] r;
        for (int k = 0; k < 9; k++) begin
            if (pix_signed)  pv = int'($signed(pix_taps[k*8 +: 8]));
            else             pv = int'(pix_taps[k*8 +: 8]);
            if (coef_signed) cv = int'($signed(coef_taps[k*8 +: 8]));
            else             cv = int'(coef_taps[k*8 +: 8]);
            acc += pv * cv;
        end
        if (!casc_bypass) begin
            sh = (casc_shift == 2'd0) ? 0 : (casc_shift == 2'd1) ? 2 :
                 (casc_shift == 2'd2) ? 4 : 8;
            acc += int'(casc_in) << sh;
        end
        r = acc[19:0];
        if (round_mode == 2'b01)      r = (r + 20'h00008) & 20'hFFFF0;
        else if (round_mode == 2'b10) r = (r + 20'h00800) & 20'hFF000;
        return r;
    endfunction

    // One clock: advance the model at the rising edge, compare at the falling one.
    task automatic cycle();
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = '0; m_out = '0; m_hq = 1'b0;
        end else begin
            if (frame_clr) begin
                m_s1 = '0; m_out = '0;
            end else if (!m_hq) begin
                m_out = m_s1; m_s1 = expect_of();
            end
            m_hq = hold;
        end
        @(negedge clk);
        vectors++;
        if (result !== m_out) begin
            fails++;
            $display("FAIL %s: result=%h expected=%h at %0t", cur_req, result, m_out, $time);
        end
    endtask

    task automatic rnd_inputs();
        pix_taps  = 72'({$urandom(), $urandom(), $urandom()});
        coef_taps = 72'({$urandom(), $urandom(), $urandom()});
        casc_in   = 16'($urandom());
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: result=%h expected=end of run", result);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        // R10: reset state
        cur_req = "R10";
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();

        // R1: tap-to-weight pairing, one weight at a time
        cur_req = "R1";
        for (int j = 0; j < 9; j++) pix_taps[j*8 +: 8] = 8'(j * 16 + 5);
        for (int k = 0; k < 9; k++) begin
            coef_taps = '0;
            coef_taps[k*8 +: 8] = 8'(k + 2);
            cycle();
        end
        for (int i = 0; i < 20; i++) begin rnd_inputs(); cycle(); end
        pix_taps = {9{8'hFF}}; coef_taps = {9{8'hFF}}; cycle();

        // R2: signed pixels, unsigned weights
        cur_req = "R2";
        pix_signed = 1'b1;
        for (int i = 0; i < 20; i++) begin rnd_inputs(); cycle(); end
        pix_taps = {9{8'h80}}; coef_taps = {9{8'hFF}}; cycle();

        // R3: signed weights, then both signed
        cur_req = "R3";
        pix_signed = 1'b0; coef_signed = 1'b1;
        for (int i = 0; i < 20; i++) begin rnd_inputs(); cycle(); end
        pix_taps = {9{8'hFF}}; coef_taps = {9{8'h80}}; cycle();
        pix_signed = 1'b1;
        pix_taps = {9{8'h80}}; cycle();
        for (int i = 0; i < 10; i++) begin rnd_inputs(); cycle(); end

        // R4: cascade added with each shift code, including wrap
        cur_req = "R4";
        casc_bypass = 1'b0;
        for (int s = 0; s < 4; s++) begin
            casc_shift = 2'(s);
            for (int i = 0; i < 8; i++) begin rnd_inputs(); cycle(); end
        end
        pix_signed = 1'b0; coef_signed = 1'b0;
        pix_taps = {9{8'hFF}}; coef_taps = {9{8'hFF}};
        casc_in = 16'hFFFF; casc_shift = 2'd3; cycle();

        // R5: bypassed cascade has no effect
        cur_req = "R5";
        casc_bypass = 1'b1;
        for (int i = 0; i < 10; i++) begin rnd_inputs(); casc_in = 16'hFFFF; cycle(); end

        // R6: round to the top 16 bits around the half point
        cur_req = "R6";
        round_mode = 2'b01;
        coef_taps = '0; coef_taps[7:0] = 8'd1;
        pix_taps = '0;
        foreach (pix_taps[b]) if (b < 0) pix_taps[b] = 1'b0;
        pix_taps[7:0] = 8'd7;  cycle();
        pix_taps[7:0] = 8'd8;  cycle();
        pix_taps[7:0] = 8'd23; cycle();
        casc_bypass = 1'b0; casc_shift = 2'd3;
        for (int i = 0; i < 15; i++) begin rnd_inputs(); cycle(); end

        // R7: round to the top 8 bits, and the unused code
        cur_req = "R7";
        round_mode = 2'b10;
        casc_in = 16'h07FF; casc_shift = 2'd0; pix_taps = '0; cycle();
        casc_in = 16'h0800; cycle();
        for (int i = 0; i < 15; i++) begin rnd_inputs(); cycle(); end
        round_mode = 2'b11;
        for (int i = 0; i < 10; i++) begin rnd_inputs(); cycle(); end
        round_mode = 2'b00;

        // R8: single impulse travels two edges
        cur_req = "R8";
        casc_bypass = 1'b1; pix_taps = '0; cycle(); cycle();
        pix_taps = {9{8'h11}}; coef_taps = {9{8'h03}}; cycle();
        pix_taps = '0;
        for (int i = 0; i < 4; i++) cycle();

        // R9: stall of one edge and of several edges
        cur_req = "R9";
        for (int i = 0; i < 12; i++) begin
            rnd_inputs();
            hold = (i == 2) || (i >= 6 && i <= 8);
            cycle();
        end
        hold = 1'b0; cycle(); cycle();

        // R11: flush, alone and together with a stall
        cur_req = "R11";
        rnd_inputs(); cycle();
        frame_clr = 1'b1; rnd_inputs(); cycle();
        frame_clr = 1'b0;
        for (int i = 0; i < 4; i++) begin rnd_inputs(); cycle(); end
        hold = 1'b1; rnd_inputs(); cycle();
        frame_clr = 1'b1; cycle();
        frame_clr = 1'b0; hold = 1'b0;
        for (int i = 0; i < 4; i++) begin rnd_inputs(); cycle(); end

        // R10: reset in mid-run clears the output and the stall
        cur_req = "R10";
        hold = 1'b1; cycle();
        rst_n = 1'b0; hold = 1'b0; rnd_inputs(); cycle();
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin rnd_inputs(); cycle(); end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule